// File: doc/BRIEF.md
# Paged Address Translator

This block turns a flat logical address issued by a processor into a physical memory address. Memory is treated as a row of equal-sized frames, and each process sees its own logical space cut into pages of the same size. The block splits the logical address into a page index (the quotient by the page size) and an in-page offset (the remainder). It looks the page index up in the active process's map to find the frame holding that page. The physical address is the frame index times the page size, plus the offset carried over unchanged.

Several processes each own a separate map, chosen by a process identifier that the block captures when it accepts a request. Software fills the maps through a single write port. Maps of different processes may point at the same frame, which lets them share read-only code pages while keeping private data pages apart. The page size is a parameter and need not be a power of two. A power-of-two size becomes a plain bit split. Any other size runs through a bit-serial divider, so a request is accepted when `req_ready` is high and is answered some cycles later by a one-cycle `resp_valid` pulse.

Top module: `atu_top`

## Requirements
- R1: For a logical address L and page size P, the page index used is L / P (integer quotient) and the offset is L mod P. With P = 10, address 5 gives page 0 offset 5, and address 17 gives page 1 offset 7.
- R2: When the page index is below NUM_PAGES and its entry is valid, `resp_paddr` = frame × P + offset, with frames counted from 0, and `resp_fault` is 0.
- R3: When the selected entry is invalid, `resp_fault` is 1 and `resp_paddr` is 0.
- R4: When the page index is NUM_PAGES or greater, `resp_fault` is 1 and `resp_paddr` is 0, whatever any entry holds.
- R5: Each process identifier has its own map. The same page may give different frames under different identifiers, and two identifiers may hold the same frame number.
- R6: A write with `wr_en` = 1 sets entry [`wr_pid`][`wr_page`] to {`wr_valid`, `wr_frame`}. It applies to a request accepted in the next cycle, and that covers both validating and invalidating an entry.
- R7: `req_pid` and `req_laddr` are sampled in the cycle a request is accepted. Changes to them afterwards do not affect that request's response.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the response cycle. `resp_valid` is a single-cycle pulse for each accepted request. `req_valid` while `req_ready` is 0 produces no response.
- R9: After reset every entry of every map is invalid, `req_ready` is 1 and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Map entry write strobe |
| wr_pid | input | PID_W | Process whose map is written |
| wr_page | input | PG_W | Page index of the written entry |
| wr_frame | input | FRAME_W | Frame number stored in the entry |
| wr_valid | input | 1 | Valid bit stored in the entry |
| req_valid | input | 1 | Translation request strobe |
| req_pid | input | PID_W | Process identifier of the request |
| req_laddr | input | LADDR_W | Logical address to translate |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | One-cycle pulse: response fields are valid |
| resp_paddr | output | PADDR_W | Physical address (0 on fault) |
| resp_fault | output | 1 | Entry invalid or page index out of range |

## Verification
The hardest situation to reach is a map update that lands in the cycle just before a request. The request is then accepted right after the write edge and must see the new entry, whether it was just made valid or just made invalid. The bench reaches this by placing its write and request tasks back to back, with no idle cycle between them, and it does this both in directed cases and in the random mix of writes and translations. Inputs that change mid-flight are covered the same way: every transaction keeps `req_valid` high with a scrambled identifier and address while the block is busy, and the bench then confirms that the response is unchanged and that no second response follows.

// File: rtl/atu_pkg.sv
package atu_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } atu_state_e;
endpackage

// File: rtl/atu_split.sv
module atu_split #(
    parameter int LADDR_W   = 12,
    parameter int PAGE_SIZE = 10,
    localparam int OFF_W    = $clog2(PAGE_SIZE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LADDR_W-1:0] dividend,
    output logic               done,
    output logic [LADDR_W-1:0] quot,
    output logic [OFF_W-1:0]   rem
);
    localparam bit IS_POW2 = (PAGE_SIZE & (PAGE_SIZE - 1)) == 0;

    generate
        if (IS_POW2) begin : g_bitsplit
            typedef struct packed {
                logic               done;
                logic [LADDR_W-1:0] quot;
                logic [OFF_W-1:0]   rem;
            } split_s;
            split_s q, d;

            always_comb begin
                d      = q;
                d.done = start;
                if (start) begin
                    d.quot = dividend >> OFF_W;
                    d.rem  = dividend[OFF_W-1:0];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end

            assign done = q.done;
            assign quot = q.quot;
            assign rem  = q.rem;
        end else begin : g_divider
            localparam int CNT_W = $clog2(LADDR_W) + 1;
            localparam logic [LADDR_W:0] DIVISOR = (LADDR_W+1)'(PAGE_SIZE);
            typedef struct packed {
                logic               busy;
                logic               done;
                logic [CNT_W-1:0]   cnt;
                logic [LADDR_W:0]   part;
                logic [LADDR_W-1:0] quo;
            } div_s;
            div_s q, d;
            logic [LADDR_W:0] trial;
            logic             take;

            always_comb begin
                d      = q;
                d.done = 1'b0;
                trial  = {q.part[LADDR_W-1:0], q.quo[LADDR_W-1]};
                take   = trial >= DIVISOR;
                if (start) begin
                    d.busy = 1'b1;
                    d.cnt  = '0;
                    d.part = '0;
                    d.quo  = dividend;
                end else if (q.busy) begin
                    d.part = take ? (trial - DIVISOR) : trial;
                    d.quo  = {q.quo[LADDR_W-2:0], take};
                    d.cnt  = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(LADDR_W - 1)) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end

            assign done = q.done;
            assign quot = q.quo;
            assign rem  = q.part[OFF_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/atu_table.sv
module atu_table #(
    parameter int NUM_PROC  = 2,
    parameter int NUM_PAGES = 8,
    parameter int FRAME_W   = 4,
    localparam int PID_W    = $clog2(NUM_PROC),
    localparam int PG_W     = $clog2(NUM_PAGES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic [PG_W-1:0]    wr_page,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic [PID_W-1:0]   rd_pid,
    input  logic [PG_W-1:0]    rd_page,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_valid
);
    typedef struct packed {
        logic [NUM_PROC-1:0][NUM_PAGES-1:0][FRAME_W-1:0] frame;
        logic [NUM_PROC-1:0][NUM_PAGES-1:0]              vld;
    } map_s;
    map_s q, d;

    always_comb begin
        d = q;
        if (wr_en && (int'(wr_pid) < NUM_PROC) && (int'(wr_page) < NUM_PAGES)) begin
            d.frame[wr_pid][wr_page] = wr_frame;
            d.vld[wr_pid][wr_page]   = wr_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_frame = '0;
        rd_valid = 1'b0;
        if ((int'(rd_pid) < NUM_PROC) && (int'(rd_page) < NUM_PAGES)) begin
            rd_frame = q.frame[rd_pid][rd_page];
            rd_valid = q.vld[rd_pid][rd_page];
        end
    end
endmodule

// File: rtl/atu_top.sv
module atu_top #(
    parameter int LADDR_W   = 12,
    parameter int PAGE_SIZE = 10,
    parameter int NUM_PROC  = 2,
    parameter int NUM_PAGES = 8,
    parameter int FRAME_W   = 4,
    localparam int PID_W    = $clog2(NUM_PROC),
    localparam int PG_W     = $clog2(NUM_PAGES),
    localparam int OFF_W    = $clog2(PAGE_SIZE),
    localparam int PADDR_W  = $clog2((2 ** FRAME_W) * PAGE_SIZE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic [PG_W-1:0]    wr_page,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic               req_valid,
    input  logic [PID_W-1:0]   req_pid,
    input  logic [LADDR_W-1:0] req_laddr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic [PADDR_W-1:0] resp_paddr,
    output logic               resp_fault
);
    import atu_pkg::*;

    typedef struct packed {
        atu_state_e         st;
        logic [PID_W-1:0]   pid;
        logic               rvalid;
        logic [PADDR_W-1:0] paddr;
        logic               fault;
    } ctl_s;
    ctl_s q, d;

    logic               accept;
    logic               split_done;
    logic [LADDR_W-1:0] split_page;
    logic [OFF_W-1:0]   split_off;
    logic [PID_W-1:0]   act_pid;
    logic [FRAME_W-1:0] tbl_frame;
    logic               tbl_valid;
    logic               in_range;

    assign accept  = (q.st == ST_IDLE) && req_valid;
    assign act_pid = q.pid;

    atu_split #(
        .LADDR_W   (LADDR_W),
        .PAGE_SIZE (PAGE_SIZE)
    ) u_split (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .dividend (req_laddr),
        .done     (split_done),
        .quot     (split_page),
        .rem      (split_off)
    );

    atu_table #(
        .NUM_PROC  (NUM_PROC),
        .NUM_PAGES (NUM_PAGES),
        .FRAME_W   (FRAME_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_pid   (wr_pid),
        .wr_page  (wr_page),
        .wr_frame (wr_frame),
        .wr_valid (wr_valid),
        .rd_pid   (act_pid),
        .rd_page  (split_page[PG_W-1:0]),
        .rd_frame (tbl_frame),
        .rd_valid (tbl_valid)
    );

    assign in_range = split_page < LADDR_W'(NUM_PAGES);

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        if (accept) begin
            d.st  = ST_BUSY;
            d.pid = req_pid;
        end
        if ((q.st == ST_BUSY) && split_done) begin
            d.st     = ST_IDLE;
            d.rvalid = 1'b1;
            d.fault  = !(in_range && tbl_valid);
            d.paddr  = d.fault ? '0
                     : PADDR_W'(tbl_frame) * PADDR_W'(PAGE_SIZE) + PADDR_W'(split_off);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign resp_valid = q.rvalid;
    assign resp_paddr = q.paddr;
    assign resp_fault = q.fault;
endmodule

// File: rtl/atu_chk.sv
module atu_chk #(
    parameter int LADDR_W   = 12,
    parameter int PAGE_SIZE = 10,
    parameter int PID_W     = 1,
    parameter int OFF_W     = 4,
    parameter int PADDR_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [LADDR_W-1:0] req_laddr,
    input logic               resp_valid,
    input logic               resp_fault,
    input logic [PADDR_W-1:0] resp_paddr,
    input logic               split_done,
    input logic [LADDR_W-1:0] split_page,
    input logic [OFF_W-1:0]   split_off,
    input logic [PID_W-1:0]   act_pid
);
    logic [LADDR_W-1:0] cap_laddr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cap_laddr <= '0;
        else if (req_valid && req_ready) cap_laddr <= req_laddr;
    end

    AST_SPLIT_RECOMBINES: assert property (@(posedge clk) disable iff (!rst_n)
        split_done |-> (int'(split_page) * PAGE_SIZE + int'(split_off) == int'(cap_laddr))) // R1
        else $error("split does not recombine");

    AST_SPLIT_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        split_done |-> (int'(split_off) < PAGE_SIZE)) // R1
        else $error("offset out of range");

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0)) // R3
        else $error("fault with nonzero address");

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready) // R8
        else $error("ready stayed high after accept");

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid) // R8
        else $error("response longer than one cycle");

    AST_RESP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(!req_ready)) // R8
        else $error("response without busy phase");

    AST_PID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(act_pid)) // R7
        else $error("process id changed mid-translation");
endmodule

bind atu_top atu_chk #(
    .LADDR_W   (LADDR_W),
    .PAGE_SIZE (PAGE_SIZE),
    .PID_W     (PID_W),
    .OFF_W     (OFF_W),
    .PADDR_W   (PADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_laddr  (req_laddr),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .split_done (split_done),
    .split_page (split_page),
    .split_off  (split_off),
    .act_pid    (act_pid)
);

// File: tb/atu_top_tb.sv
module atu_top_tb;
    localparam int LADDR_W   = 12;
    localparam int PAGE_SIZE = 10;
    localparam int NUM_PROC  = 2;
    localparam int NUM_PAGES = 8;
    localparam int FRAME_W   = 4;
    localparam int PID_W     = $clog2(NUM_PROC);
    localparam int PG_W      = $clog2(NUM_PAGES);
    localparam int PADDR_W   = $clog2((2 ** FRAME_W) * PAGE_SIZE);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [PID_W-1:0]   wr_pid = '0;
    logic [PG_W-1:0]    wr_page = '0;
    logic [FRAME_W-1:0] wr_frame = '0;
    logic               wr_valid = 1'b0;
    logic               req_valid = 1'b0;
    logic [PID_W-1:0]   req_pid = '0;
    logic [LADDR_W-1:0] req_laddr = '0;
    logic               req_ready;
    logic               resp_valid;
    logic [PADDR_W-1:0] resp_paddr;
    logic               resp_fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    int mdl_frame [NUM_PROC][NUM_PAGES];
    bit mdl_vld   [NUM_PROC][NUM_PAGES];

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    atu_top #(
        .LADDR_W   (LADDR_W),
        .PAGE_SIZE (PAGE_SIZE),
        .NUM_PROC  (NUM_PROC),
        .NUM_PAGES (NUM_PAGES),
        .FRAME_W   (FRAME_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_pid     (wr_pid),
        .wr_page    (wr_page),
        .wr_frame   (wr_frame),
        .wr_valid   (wr_valid),
        .req_valid  (req_valid),
        .req_pid    (req_pid),
        .req_laddr  (req_laddr),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_paddr (resp_paddr),
        .resp_fault (resp_fault)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void expect_tr(input int pid, input int laddr,
                                      output bit fault, output int paddr);
        int page = laddr / PAGE_SIZE;
        int off  = laddr % PAGE_SIZE;
        fault = (page >= NUM_PAGES) || !mdl_vld[pid][page];
        paddr = fault ? 0 : mdl_frame[pid][page] * PAGE_SIZE + off;
    endfunction

    task automatic write_entry(input int pid, input int page, input int frame, input bit vld);
        @(negedge clk);
        wr_en = 1'b1; wr_pid = PID_W'(pid); wr_page = PG_W'(page);
        wr_frame = FRAME_W'(frame); wr_valid = vld;
        @(negedge clk);
        wr_en = 1'b0;
        mdl_frame[pid][page] = frame;
        mdl_vld[pid][page]   = vld;
    endtask

    // Request is accepted at the first posedge after the current negedge.
    task automatic translate(input int pid, input int laddr, input string req);
        bit efault;
        int epaddr;
        int n = 0;
        bit ready_bad = 1'b0;
        expect_tr(pid, laddr, efault, epaddr);
        if (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_pid = PID_W'(pid); req_laddr = LADDR_W'(laddr);
        @(negedge clk);
        // scrambled inputs held while busy must be ignored (R7, R8)
        req_pid   = PID_W'(pid + 1);
        req_laddr = LADDR_W'(laddr ^ 12'h5a5);
        while (!resp_valid && n < 200) begin
            if (req_ready) ready_bad = 1'b1;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(n < 200, "R8", "response timeout", n, 200);
        chk(!ready_bad, "R8", "ready high while busy", int'(ready_bad), 0);
        chk(resp_fault == efault, req, $sformatf("fault pid=%0d laddr=%0d", pid, laddr),
            int'(resp_fault), int'(efault));
        chk(int'(resp_paddr) == epaddr, req, $sformatf("paddr pid=%0d laddr=%0d", pid, laddr),
            int'(resp_paddr), epaddr);
        @(negedge clk);
        chk(!resp_valid, "R8", "extra response pulse", int'(resp_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < NUM_PROC; p++)
            for (int g = 0; g < NUM_PAGES; g++) begin
                mdl_frame[p][g] = 0;
                mdl_vld[p][g]   = 1'b0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R9", "resp_valid after reset", int'(resp_valid), 0);
        translate(0, 5, "R9");
        translate(1, 0, "R9");

        // process 0 map, process 1 shares code pages 0,1 and has private page 2
        write_entry(0, 0, 4, 1'b1);
        write_entry(0, 1, 1, 1'b1);
        write_entry(0, 2, 6, 1'b1);
        write_entry(0, 3, 2, 1'b1);
        write_entry(1, 0, 4, 1'b1);
        write_entry(1, 1, 1, 1'b1);
        write_entry(1, 2, 9, 1'b1);

        translate(0, 5, "R1");    // page 0 off 5 -> 45
        translate(0, 17, "R1");   // page 1 off 7 -> 17
        translate(0, 29, "R2");   // page 2 off 9 -> 69
        translate(0, 30, "R2");   // page 3 off 0 -> 20
        translate(1, 29, "R5");   // private -> 99
        translate(1, 12, "R5");   // shared  -> 12
        translate(1, 35, "R3");   // page 3 invalid for pid 1
        translate(0, 80, "R4");   // page 8
        translate(0, 4095, "R4");
        translate(0, 79, "R3");   // page 7 not yet valid
        write_entry(0, 7, 15, 1'b1);
        translate(0, 79, "R6");   // next-cycle visibility -> 159
        write_entry(0, 0, 4, 1'b0);
        translate(0, 5, "R6");    // invalidated -> fault
        write_entry(0, 7, 3, 1'b1);
        translate(0, 70, "R6");   // rewritten frame -> 30

        for (int i = 0; i < 400; i++) begin
            if (($urandom % 4) == 0) begin
                write_entry(int'($urandom % NUM_PROC), int'($urandom % NUM_PAGES),
                            int'($urandom % (2 ** FRAME_W)), ($urandom % 4) != 0);
            end else begin
                int la = (($urandom % 10) < 7) ? int'($urandom % 100)
                                                : int'($urandom % (2 ** LADDR_W));
                translate(int'($urandom % NUM_PROC), la, "R2");
            end
        end

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule